// File: doc/BRIEF.md
# Power-Down Hold Controller

This block puts a region of logic into a low-power hold state from one power-down request pin and brings it back out. While held, the inputs it guards read as zero to the core logic and every output enable it manages is forced off. A clock-enable output is driven low so that user registers keep their contents. A status output tells the rest of the system that the hold is in force.

The request pin passes through a two-stage synchronizer. Entry takes two steps. In the first cycle the outputs are turned off and the inputs are blocked while the clock enable stays high. In the following cycle the clock enable drops. Exit is synchronous as well. After the request goes away, the block counts a programmable number of wake cycles. It then releases inputs, outputs and the clock enable on the same edge. A request seen again during the wake count sends the block straight back to the hold state, and nothing is released.

Top module: `pwrHoldCtrl`

## Requirements
- R1: The request is sampled by two flops. A request present at clock edge k moves the block out of the active state at edge k+2. When reset is released with the request already high, the first change of state happens on the third edge.
- R2: While `pdStatus` is high, `coreIn` is all zeros whatever `rawIn` holds.
- R3: While `pdStatus` is high, every bit of `padOe` is 0.
- R4: `clkEn` is low in the hold state and during the wake count, and high at all other times.
- R5: Entry lasts exactly one cycle. In that cycle `pdStatus` is 1, `padOe` is 0, the inputs are blocked and `clkEn` is still 1. `clkEn` falls on the next edge.
- R6: `pdStatus` rises on the edge on which entry begins. It falls only on the edge on which the block is fully active again.
- R7: After the synchronized request goes low in the hold state, the wake count lasts WAKE_CYC cycles. On the following edge `coreIn`, `padOe` and `clkEn` are all released together and `pdStatus` falls.
- R8: A synchronized request seen during the wake count returns the block to the hold state. This applies on the last wake cycle too, and no signal is released.
- R9: Asynchronous reset (`rstN` low) puts the block in the active state at once: `pdStatus`=0, `clkEn`=1, `padOe`=`coreOe`, `coreIn`=`rawIn`.
- R10: A user register whose enable is `clkEn` keeps its value from the first hold cycle through the whole wake count.
- R11: In the active state `coreIn` equals `rawIn` and `padOe` equals `coreOe` for any bit patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdReq | input | 1 | Power-down request, asynchronous to clk |
| rawIn | input | IN_W | Inputs from the pins, before gating |
| coreOe | input | OUT_W | Output enables requested by the core |
| coreIn | output | IN_W | Gated inputs seen by the core |
| padOe | output | OUT_W | Output enables sent to the pads |
| clkEn | output | 1 | Enable for user registers (low holds them) |
| pdStatus | output | 1 | High while not fully active |

## Verification
The assertions assume that `rawIn` and `coreOe` are settled at each rising edge. They also assume that `pdReq` may change at any time, because the synchronizer absorbs it. The stimulus changes all inputs only on falling edges and samples results a quarter period after the rising edge. One vector table covers these cases: a pulse that lasts a single cycle, a request made again on the last wake cycle, and a wake that runs to completion, each with fresh bit patterns on the data inputs.

// File: rtl/pwrHoldPkg.sv
package pwrHoldPkg;

  typedef enum logic [1:0] {
    stActive   = 2'd0,
    stEntering = 2'd1,
    stDown     = 2'd2,
    stWaking   = 2'd3
  } holdState_t;

  // Strobes from control to datapath, describing the state being entered
  typedef struct packed {
    logic blockIn;
    logic oeOff;
    logic ceOff;
    logic status;
  } holdStrobe_t;

endpackage

// File: rtl/pwrHoldSync.sv
module pwrHoldSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/pwrHoldCtrl.sv
module pwrHoldFsm
  import pwrHoldPkg::*;
#(
  parameter int WAKE_CYC = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pdSync,
  output holdStrobe_t strb
);
  localparam int CW = (WAKE_CYC < 2) ? 1 : $clog2(WAKE_CYC);
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYC - 1);

  holdState_t state, nextState;
  logic [CW-1:0] wakeCnt, nextCnt;

  always_comb begin
    nextState = state;
    nextCnt   = wakeCnt;
    unique case (state)
      stActive:   if (pdSync) nextState = stEntering;
      stEntering: nextState = stDown;
      stDown: if (!pdSync) begin
        nextState = stWaking;
        nextCnt   = '0;
      end
      stWaking: begin
        if (pdSync)                nextState = stDown;
        else if (wakeCnt == LAST)  nextState = stActive;
        else                       nextCnt   = wakeCnt + 1'b1;
      end
      default: nextState = stActive;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= stActive;
      wakeCnt <= '0;
    end else begin
      state   <= nextState;
      wakeCnt <= nextCnt;
    end
  end

  // Strobes describe the state taking effect at the next edge
  always_comb begin
    strb.status  = (nextState != stActive);
    strb.blockIn = (nextState != stActive);
    strb.oeOff   = (nextState != stActive);
    strb.ceOff   = (nextState == stDown) || (nextState == stWaking);
  end
endmodule

// File: rtl/pwrHoldGate.sv
module pwrHoldGate
  import pwrHoldPkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  holdStrobe_t      strb,
  input  logic [IN_W-1:0]  rawIn,
  input  logic [OUT_W-1:0] coreOe,
  output logic [IN_W-1:0]  coreIn,
  output logic [OUT_W-1:0] padOe,
  output logic             clkEn,
  output logic             pdStatus
);
  logic blockQ, oeOffQ, ceOffQ, statusQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blockQ  <= 1'b0;
      oeOffQ  <= 1'b0;
      ceOffQ  <= 1'b0;
      statusQ <= 1'b0;
    end else begin
      blockQ  <= strb.blockIn;
      oeOffQ  <= strb.oeOff;
      ceOffQ  <= strb.ceOff;
      statusQ <= strb.status;
    end
  end

  for (genvar i = 0; i < IN_W; i++) begin : gIn
    assign coreIn[i] = rawIn[i] & ~blockQ;
  end
  for (genvar j = 0; j < OUT_W; j++) begin : gOe
    assign padOe[j] = coreOe[j] & ~oeOffQ;
  end

  assign clkEn    = ~ceOffQ;
  assign pdStatus = statusQ;
endmodule

// File: rtl/pwrHoldCtrl_top.sv
module pwrHoldCtrl
  import pwrHoldPkg::*;
#(
  parameter int IN_W        = 8,
  parameter int OUT_W       = 4,
  parameter int WAKE_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pdReq,
  input  logic [IN_W-1:0]  rawIn,
  input  logic [OUT_W-1:0] coreOe,
  output logic [IN_W-1:0]  coreIn,
  output logic [OUT_W-1:0] padOe,
  output logic             clkEn,
  output logic             pdStatus
);
  logic        pdSync;
  holdStrobe_t strb;

  pwrHoldSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(pdReq), .syncOut(pdSync)
  );

  pwrHoldFsm #(.WAKE_CYC(WAKE_CYC)) uFsm (
    .clk(clk), .rstN(rstN), .pdSync(pdSync), .strb(strb)
  );

  pwrHoldGate #(.IN_W(IN_W), .OUT_W(OUT_W)) uGate (
    .clk(clk), .rstN(rstN), .strb(strb), .rawIn(rawIn), .coreOe(coreOe),
    .coreIn(coreIn), .padOe(padOe), .clkEn(clkEn), .pdStatus(pdStatus)
  );
endmodule

// File: rtl/pwrHoldCheck.sv
module pwrHoldCheck #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [IN_W-1:0]  rawIn,
  input logic [OUT_W-1:0] coreOe,
  input logic [IN_W-1:0]  coreIn,
  input logic [OUT_W-1:0] padOe,
  input logic             clkEn,
  input logic             pdStatus
);
  a_r2_inputs_zero: assert property (@(posedge clk) disable iff (!rstN)
    pdStatus |-> (coreIn == '0));

  a_r3_oe_off: assert property (@(posedge clk) disable iff (!rstN)
    pdStatus |-> (padOe == '0));

  a_r4_ce_needs_status: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |-> pdStatus);

  a_r5_ce_falls_late: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkEn) |-> $past(pdStatus) && $past(padOe == '0));

  a_r6_entry_keeps_ce: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdStatus) |-> clkEn);

  a_r7_release_together: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pdStatus) |-> clkEn && !$past(clkEn) && (coreIn == rawIn) && (padOe == coreOe));

  a_r11_active_pass: assert property (@(posedge clk) disable iff (!rstN)
    !pdStatus |-> (coreIn == rawIn) && (padOe == coreOe) && clkEn);
endmodule

bind pwrHoldCtrl pwrHoldCheck #(.IN_W(IN_W), .OUT_W(OUT_W)) uCheck (
  .clk(clk), .rstN(rstN), .rawIn(rawIn), .coreOe(coreOe), .coreIn(coreIn),
  .padOe(padOe), .clkEn(clkEn), .pdStatus(pdStatus)
);

// File: tb/pwrHoldCtrl_test.sv
module pwrHoldCtrl_test;
  localparam int IN_W = 8;
  localparam int OUT_W = 4;
  localparam int NV = 25;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pdReq = 1'b0;
  logic [IN_W-1:0] rawIn = '0;
  logic [OUT_W-1:0] coreOe = '0;
  logic [IN_W-1:0] coreIn;
  logic [OUT_W-1:0] padOe;
  logic clkEn, pdStatus;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int userCnt = 0;

  always #10 clk = ~clk;

  // user register held by clkEn (R10)
  always @(posedge clk) if (clkEn) userCnt <= userCnt + 1;

  pwrHoldCtrl uut (
    .clk(clk), .rstN(rstN), .pdReq(pdReq), .rawIn(rawIn), .coreOe(coreOe),
    .coreIn(coreIn), .padOe(padOe), .clkEn(clkEn), .pdStatus(pdStatus)
  );

  // per-cycle request and expected {status, oeOn, ce, inPass}
  localparam logic [NV-1:0] PD_SEQ = 25'b0000000010000000100001110;
  localparam logic [3:0] EXP [NV] = '{
    4'b0111, 4'b0111, 4'b0111, 4'b1010, 4'b1000, 4'b1000, 4'b1000, 4'b1000,
    4'b1000, 4'b1000, 4'b1000, 4'b1000, 4'b1000, 4'b1000, 4'b1000, 4'b0111,
    4'b0111, 4'b0111, 4'b1010, 4'b1000, 4'b1000, 4'b1000, 4'b1000, 4'b1000,
    4'b0111};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkAll(input string req, input logic [3:0] e);
    chk({req, " status"}, 32'(pdStatus), 32'(e[3]));
    chk({req, " R3 padOe"}, 32'(padOe), e[2] ? 32'(coreOe) : 32'h0);
    chk({req, " R4 clkEn"}, 32'(clkEn), 32'(e[1]));
    chk({req, " R2 coreIn"}, 32'(coreIn), e[0] ? 32'(rawIn) : 32'h0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cntAtDown;
    rawIn = 8'hA5;
    coreOe = 4'hB;
    #15;
    chkAll("R9 reset", 4'b0111);
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    // vector table: R1 R5 R6 R7 R8 R11
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pdReq = PD_SEQ[i];
      rawIn = 8'(i * 37 + 11);
      coreOe = 4'(i * 5 + 3);
      @(posedge clk);
      #5;
      chkAll($sformatf("R6/R7/R8 vec%0d", i), EXP[i]);
      if (i == 4) cntAtDown = userCnt;
      if (i == 15) chk("R10 held count", 32'(userCnt), 32'(cntAtDown));
      if (i == 16) chk("R10 resumes", 32'(userCnt), 32'(cntAtDown + 1));
    end

    // R9: reset during hold returns to active at once
    @(negedge clk); pdReq = 1'b1;
    repeat (4) @(negedge clk);
    chkAll("R9 pre-reset hold", 4'b1000);
    rstN = 1'b0;
    #1;
    chkAll("R9 async reset", 4'b0111);
    // R1: release with request high, change on third edge
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #5; chkAll("R1 edge1", 4'b0111);
    @(posedge clk); #5; chkAll("R1 edge2", 4'b0111);
    @(posedge clk); #5; chkAll("R1 R5 edge3", 4'b1010);
    @(posedge clk); #5; chkAll("R5 edge4", 4'b1000);
    // R2: inputs stay blocked under varying patterns
    @(negedge clk); rawIn = 8'hFF; coreOe = 4'hF;
    #1; chkAll("R2 blocked ff", 4'b1000);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule